// File: doc/BRIEF.md
# Two-word burst DDR SRAM controller

This block is the bus-master side of a synchronous SRAM that moves data as a fixed two-beat burst on both edges of its clock. A user request carries a read or write flag, an address and, for a write, two data words. The controller turns each accepted request into one load cycle on the memory side. A load cycle is an active-low load strobe, a read/write select and the address. Every other cycle is driven as a no-operation.

Double-data-rate transfers are modelled with separate rise and fall data lanes in a single clock domain. Write data goes out on both lanes in the cycle after a write's load cycle. Read data comes back half a cycle later than that: the first beat sits on the fall lane in the cycle after the load cycle, and the second beat sits on the rise lane one cycle later. The memory forms the second burst address itself by inverting address bit 0. The controller captures both beats and hands them to the user as one two-word result with a single-cycle valid pulse.

Turnaround is enforced at the request handshake. After a write's load cycle no load may follow in the next cycle. After a read's load cycle a write may not follow in the next cycle, so that read and write data never share the data bus. Reads may run back to back.

Top module: `ddr2b_sram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the memory side is idle: `mem_ld_n` and `mem_rw_n` are 1, `mem_wd_oe` is 0, both write lanes are 0, `rd_valid` is 0, both read words are 0, and `ready` is 1.
- R2: A cycle with no accepted request in the previous cycle is a no-operation: `mem_ld_n` is 1 and `mem_rw_n` is held at 1.
- R3: A request is accepted at a rising clock edge where `req` and `ready` are both 1. In the next cycle, and only in that cycle, `mem_ld_n` is 0, `mem_addr` equals the request address, and `mem_rw_n` is 0 for a write (`req_wr`=1) or 1 for a read.
- R4: In the cycle after a write's load cycle, `mem_wd_oe` is 1, `mem_wd_rise` carries the first word (for address A) and `mem_wd_fall` carries the second word (for address A with bit 0 inverted). In every other cycle `mem_wd_oe` is 0 and both write lanes are 0.
- R5: `ready` is 0 in every cycle that is a write's load cycle, so the cycle after a write's load cycle is always a no-operation.
- R6: For a read whose load cycle is t, `rd_valid` is 1 for exactly one cycle, in cycle t+3.
- R7: Outside the cycles named in R6, `rd_valid` is 0 and `rd_word0`/`rd_word1` keep their last values. Values on the read lanes outside a read's capture cycles have no effect.
- R8: For a read whose load cycle is t, `rd_word0` is the value of `mem_rd_fall` in cycle t+1 (first beat, address A). `rd_word1` is the value of `mem_rd_rise` in cycle t+2 (second beat, address A with bit 0 inverted).
- R9: In a read's load cycle, `ready` is 0 when `req_wr` is 1 and 1 when `req_wr` is 0. A write therefore follows a read with at least one idle cycle between their load cycles, while reads may issue in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory source clock; one cycle holds one rise and one fall data slot |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | User request valid |
| req_wr | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Burst start address A |
| req_wd0 | input | DATA_W | Write word for address A |
| req_wd1 | input | DATA_W | Write word for address A with bit 0 inverted |
| ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | One-cycle pulse: both read words are present |
| rd_word0 | output | DATA_W | Read word from address A |
| rd_word1 | output | DATA_W | Read word from address A with bit 0 inverted |
| mem_ld_n | output | 1 | Active-low load strobe |
| mem_rw_n | output | 1 | Read/write select: 0 = write, 1 = read |
| mem_addr | output | ADDR_W | Memory address, valid in load cycles |
| mem_wd_oe | output | 1 | Controller drives the data bus this cycle |
| mem_wd_rise | output | DATA_W | Write data lane for the rising-edge slot |
| mem_wd_fall | output | DATA_W | Write data lane for the falling-edge slot |
| mem_rd_rise | input | DATA_W | Read data lane for the returned-clock rising-edge slot |
| mem_rd_fall | input | DATA_W | Read data lane for the returned-clock falling-edge slot |

## Verification
The bench drives back-to-back writes, back-to-back reads and reads followed at once by writes. A controller with a missing turnaround would show a second load strobe right after a write, or let a write's data cycle land on the second read beat. Reads at odd addresses catch swapped lane capture or swapped word order. Each read result is compared with data the bench itself wrote, so a one-cycle slip in the read pipeline gives a misplaced valid pulse or a word from the wrong lane. Changing garbage on the read lanes during idle cycles would show up as a stray valid pulse or as drifting read words in a design that samples the bus when it should not.

// File: rtl/ddr2b_pkg.sv
// Shared types for the two-word burst SRAM controller.
// Assumes: one command per clock at most; the command kind is all that
// the data-path submodules need to know about a load cycle.
package ddr2b_pkg;

    // Kind of memory cycle currently on the command pins.
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    // True when a cycle of this kind strobes the load pin.
    function automatic logic op_is_load(op_e op);
        return op != OP_NOP;
    endfunction

endpackage

// File: rtl/ddr2b_issue.sv
// Command issue stage: accepts user requests and registers them onto the
// load strobe, read/write select and address pins.
// Assumes: the request fields stay stable while req is high and ready low;
// ready may depend on req_wr (read-to-write turnaround check).
module ddr2b_issue
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wd0,
    input  logic [DATA_W-1:0] req_wd1,
    output logic              ready,
    output op_e               op_now,
    output logic              mem_ld_n,
    output logic              mem_rw_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] wd0_now,
    output logic [DATA_W-1:0] wd1_now
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd0_q;
    logic [DATA_W-1:0] wd1_q;
    logic              accept;

    // Decide whether the next cycle may carry a new load.
    always_comb begin
        ready  = !((op_q == OP_WR) || ((op_q == OP_RD) && req_wr));
        accept = req && ready;
    end

    // Register the accepted request as next cycle's command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            addr_q <= '0;
            wd0_q  <= '0;
            wd1_q  <= '0;
        end else begin
            op_q <= accept ? (req_wr ? OP_WR : OP_RD) : OP_NOP;
            if (accept) begin
                addr_q <= req_addr;
                wd0_q  <= req_wd0;
                wd1_q  <= req_wd1;
            end
        end
    end

    // Decode the registered command onto the memory pins.
    always_comb begin
        op_now   = op_q;
        mem_ld_n = !op_is_load(op_q);
        mem_rw_n = (op_q != OP_WR);
        mem_addr = addr_q;
        wd0_now  = wd0_q;
        wd1_now  = wd1_q;
    end

    // R5: a write's load cycle is always followed by a no-operation.
    a_r5_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WR) |=> (op_q == OP_NOP));

    // R9: a read's load cycle is never followed directly by a write.
    a_r9_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_RD) |=> (op_q != OP_WR));

endmodule

// File: rtl/ddr2b_wrpath.sv
// Write data path: launches the two burst words on the rise and fall
// lanes one cycle after a write's load cycle.
// Assumes: the issue stage holds the write words while the command is on
// the pins, and never issues two loads in a row after a write.
module ddr2b_wrpath
    import ddr2b_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_now,
    input  logic [DATA_W-1:0] wd0_now,
    input  logic [DATA_W-1:0] wd1_now,
    output logic              mem_wd_oe,
    output logic [DATA_W-1:0] mem_wd_rise,
    output logic [DATA_W-1:0] mem_wd_fall
);

    // Delay write words by one cycle; lanes are zero when not driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wd_oe   <= 1'b0;
            mem_wd_rise <= '0;
            mem_wd_fall <= '0;
        end else if (op_now == OP_WR) begin
            mem_wd_oe   <= 1'b1;
            mem_wd_rise <= wd0_now;
            mem_wd_fall <= wd1_now;
        end else begin
            mem_wd_oe   <= 1'b0;
            mem_wd_rise <= '0;
            mem_wd_fall <= '0;
        end
    end

    // R4: the bus is driven only in the cycle after a write command.
    a_r4_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wd_oe |-> $past(op_now == OP_WR));

    // R4: lanes stay quiet whenever the bus is not driven.
    a_r4_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wd_oe |-> (mem_wd_rise == '0) && (mem_wd_fall == '0));

endmodule

// File: rtl/ddr2b_rdpath.sv
// Read capture path: takes the first beat from the fall lane one cycle
// after a read's load cycle and the second beat from the rise lane one
// cycle later, then presents both words with a one-cycle valid pulse.
// Assumes: the read lanes hold valid data only in those capture cycles.
module ddr2b_rdpath
    import ddr2b_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_now,
    input  logic [DATA_W-1:0] mem_rd_rise,
    input  logic [DATA_W-1:0] mem_rd_fall,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word0,
    output logic [DATA_W-1:0] rd_word1
);

    localparam int BEATS = 2;

    logic [BEATS-1:0]  stage_q;
    logic [DATA_W-1:0] first_q;

    // Track which pending reads have a beat on the lanes this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[BEATS-2:0], (op_now == OP_RD)};
        end
    end

    // Hold the first beat until the second one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
        end else if (stage_q[0]) begin
            first_q <= mem_rd_fall;
        end
    end

    // Present both words together and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word0 <= '0;
            rd_word1 <= '0;
        end else if (stage_q[BEATS-1]) begin
            rd_valid <= 1'b1;
            rd_word0 <= first_q;
            rd_word1 <= mem_rd_rise;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R6: every valid pulse belongs to a read issued three cycles earlier.
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(op_now == OP_RD, 3));

    // R7: the returned words do not move without a valid pulse.
    a_r7_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_word0) && $stable(rd_word1));

endmodule

// File: rtl/ddr2b_sram_ctl.sv
// Top of the two-word burst DDR SRAM controller: issue stage, write data
// lanes and read capture lanes.
// Assumes: one clock domain; the double-data-rate slots of each cycle are
// carried as separate rise and fall lanes.
module ddr2b_sram_ctl
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wd0,
    input  logic [DATA_W-1:0] req_wd1,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_word0,
    output logic [DATA_W-1:0] rd_word1,
    output logic              mem_ld_n,
    output logic              mem_rw_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wd_oe,
    output logic [DATA_W-1:0] mem_wd_rise,
    output logic [DATA_W-1:0] mem_wd_fall,
    input  logic [DATA_W-1:0] mem_rd_rise,
    input  logic [DATA_W-1:0] mem_rd_fall
);

    op_e               op_now;
    logic [DATA_W-1:0] wd0_now;
    logic [DATA_W-1:0] wd1_now;

    ddr2b_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) issue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_wd0  (req_wd0),
        .req_wd1  (req_wd1),
        .ready    (ready),
        .op_now   (op_now),
        .mem_ld_n (mem_ld_n),
        .mem_rw_n (mem_rw_n),
        .mem_addr (mem_addr),
        .wd0_now  (wd0_now),
        .wd1_now  (wd1_now)
    );

    ddr2b_wrpath #(.DATA_W(DATA_W)) wrpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_now      (op_now),
        .wd0_now     (wd0_now),
        .wd1_now     (wd1_now),
        .mem_wd_oe   (mem_wd_oe),
        .mem_wd_rise (mem_wd_rise),
        .mem_wd_fall (mem_wd_fall)
    );

    ddr2b_rdpath #(.DATA_W(DATA_W)) rdpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_now      (op_now),
        .mem_rd_rise (mem_rd_rise),
        .mem_rd_fall (mem_rd_fall),
        .rd_valid    (rd_valid),
        .rd_word0    (rd_word0),
        .rd_word1    (rd_word1)
    );

    // R4: write data at the pins follows a write load seen at the pins.
    a_r4_pins_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wd_oe |-> $past(!mem_ld_n && !mem_rw_n));

    // R8: data is never driven in a cycle whose beats belong to a read.
    a_r8_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_ld_n && mem_rw_n) |-> !mem_wd_oe);

endmodule

// File: tb/ddr2b_sram_ctl_tb.sv
module ddr2b_sram_ctl_tb_top;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic          req_wr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wd0;
    logic [DW-1:0] req_wd1;
    logic          ready;
    logic          rd_valid;
    logic [DW-1:0] rd_word0;
    logic [DW-1:0] rd_word1;
    logic          mem_ld_n;
    logic          mem_rw_n;
    logic [AW-1:0] mem_addr;
    logic          mem_wd_oe;
    logic [DW-1:0] mem_wd_rise;
    logic [DW-1:0] mem_wd_fall;
    logic [DW-1:0] mem_rd_rise;
    logic [DW-1:0] mem_rd_fall;

    always #5 clk = ~clk;

    ddr2b_sram_ctl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wd0(req_wd0), .req_wd1(req_wd1),
        .ready(ready), .rd_valid(rd_valid), .rd_word0(rd_word0),
        .rd_word1(rd_word1), .mem_ld_n(mem_ld_n), .mem_rw_n(mem_rw_n),
        .mem_addr(mem_addr), .mem_wd_oe(mem_wd_oe),
        .mem_wd_rise(mem_wd_rise), .mem_wd_fall(mem_wd_fall),
        .mem_rd_rise(mem_rd_rise), .mem_rd_fall(mem_rd_fall)
    );

    typedef struct {
        bit            idle;
        bit            wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
    } stim_t;

    typedef struct {
        int            due;
        logic [DW-1:0] w0;
        logic [DW-1:0] w1;
    } rexp_t;

    stim_t sq[$];
    rexp_t rq[$];

    logic [DW-1:0] mem  [DEPTH];
    logic [DW-1:0] refm [DEPTH];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    // reference model state: command on pins now, previous command
    bit            m_v = 0, m_wr = 0;
    logic [AW-1:0] m_a = '0;
    logic [DW-1:0] m_d0 = '0, m_d1 = '0;
    bit            p_wr = 0;
    logic [DW-1:0] p_d0 = '0, p_d1 = '0;
    logic [DW-1:0] lw0 = '0, lw1 = '0;
    // memory model pipeline built from the pins
    bit            k1_rd = 0, k1_wr = 0, k2_rd = 0;
    logic [AW-1:0] k1_a = '0, k2_a = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d %s: actual %0h expected %0h", tag, cyc, what, act, exp);
        end
    endtask

    task automatic push_wr(input int a, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        stim_t s;
        s.idle = 0; s.wr = 1; s.a = AW'(a); s.d0 = d0; s.d1 = d1;
        sq.push_back(s);
    endtask

    task automatic push_rd(input int a);
        stim_t s;
        s.idle = 0; s.wr = 0; s.a = AW'(a); s.d0 = '0; s.d1 = '0;
        sq.push_back(s);
    endtask

    task automatic push_idle(input int n);
        stim_t s;
        s.idle = 1; s.wr = 0; s.a = '0; s.d0 = '0; s.d1 = '0;
        for (int i = 0; i < n; i++) sq.push_back(s);
    endtask

    // One clock cycle: compare outputs, run the memory model, drive inputs.
    task automatic step();
        bit            exp_ready;
        bit            acc;
        string         tag;
        @(negedge clk);
        cyc++;
        // R2/R3: command pins
        chk(mem_ld_n == !m_v, m_v ? "R3" : "R2", "mem_ld_n", 32'(mem_ld_n), 32'(!m_v));
        if (m_v) begin
            chk(mem_rw_n == !m_wr, "R3", "mem_rw_n", 32'(mem_rw_n), 32'(!m_wr));
            chk(mem_addr == m_a, "R3", "mem_addr", 32'(mem_addr), 32'(m_a));
        end else begin
            chk(mem_rw_n == 1'b1, "R2", "mem_rw_n idle", 32'(mem_rw_n), 32'd1);
        end
        // R4: write lanes
        chk(mem_wd_oe == p_wr, "R4", "mem_wd_oe", 32'(mem_wd_oe), 32'(p_wr));
        chk(mem_wd_rise == (p_wr ? p_d0 : '0), "R4", "mem_wd_rise", 32'(mem_wd_rise), 32'(p_wr ? p_d0 : '0));
        chk(mem_wd_fall == (p_wr ? p_d1 : '0), "R4", "mem_wd_fall", 32'(mem_wd_fall), 32'(p_wr ? p_d1 : '0));
        // R6/R7/R8: read return
        if (rq.size() > 0 && rq[0].due == cyc) begin
            chk(rd_valid == 1'b1, "R6", "rd_valid", 32'(rd_valid), 32'd1);
            chk(rd_word0 == rq[0].w0, "R8", "rd_word0", 32'(rd_word0), 32'(rq[0].w0));
            chk(rd_word1 == rq[0].w1, "R8", "rd_word1", 32'(rd_word1), 32'(rq[0].w1));
            lw0 = rq[0].w0;
            lw1 = rq[0].w1;
            void'(rq.pop_front());
        end else begin
            chk(rd_valid == 1'b0, "R7", "rd_valid", 32'(rd_valid), 32'd0);
            chk(rd_word0 == lw0, "R7", "rd_word0 hold", 32'(rd_word0), 32'(lw0));
            chk(rd_word1 == lw1, "R7", "rd_word1 hold", 32'(rd_word1), 32'(lw1));
        end
        // memory model: second address is the first with bit 0 inverted
        if (k1_wr && mem_wd_oe) begin
            mem[k1_a]        = mem_wd_rise;
            mem[k1_a ^ AW'(1)] = mem_wd_fall;
        end
        mem_rd_fall = k1_rd ? mem[k1_a] : DW'(32'hBEEF ^ (cyc * 7));
        mem_rd_rise = k2_rd ? mem[k2_a ^ AW'(1)] : DW'(32'h5A3C ^ (cyc * 13));
        k2_rd = k1_rd;
        k2_a  = k1_a;
        k1_rd = !mem_ld_n && mem_rw_n;
        k1_wr = !mem_ld_n && !mem_rw_n;
        k1_a  = mem_addr;
        // stimulus
        if (sq.size() > 0 && !sq[0].idle) begin
            req      = 1'b1;
            req_wr   = sq[0].wr;
            req_addr = sq[0].a;
            req_wd0  = sq[0].d0;
            req_wd1  = sq[0].d1;
        end else begin
            if (sq.size() > 0) void'(sq.pop_front());
            req      = 1'b0;
            req_wr   = 1'($urandom_range(0, 1));
            req_addr = AW'($urandom);
            req_wd0  = DW'($urandom);
            req_wd1  = DW'($urandom);
        end
        #1;
        exp_ready = !(m_v && m_wr) && !(m_v && !m_wr && req_wr);
        tag = (m_v && m_wr) ? "R5" : (m_v ? "R9" : "R3");
        chk(ready == exp_ready, tag, "ready", 32'(ready), 32'(exp_ready));
        acc = req && exp_ready;
        // advance the model
        p_wr = m_v && m_wr;
        p_d0 = m_d0;
        p_d1 = m_d1;
        m_v  = acc;
        m_wr = req_wr;
        m_a  = req_addr;
        m_d0 = req_wd0;
        m_d1 = req_wd1;
        if (acc) begin
            if (req_wr) begin
                refm[req_addr]          = req_wd0;
                refm[req_addr ^ AW'(1)] = req_wd1;
            end else begin
                rexp_t r;
                r.due = cyc + 4;
                r.w0  = refm[req_addr];
                r.w1  = refm[req_addr ^ AW'(1)];
                rq.push_back(r);
            end
            void'(sq.pop_front());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]  = DW'(16'h1000 + i * 3);
            refm[i] = DW'(16'h1000 + i * 3);
        end
        rst_n = 1'b0;
        req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wd0 = '0; req_wd1 = '0;
        mem_rd_rise = 16'hFFFF; mem_rd_fall = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ld_n == 1'b1, "R1", "mem_ld_n", 32'(mem_ld_n), 32'd1);
        chk(mem_rw_n == 1'b1, "R1", "mem_rw_n", 32'(mem_rw_n), 32'd1);
        chk(mem_wd_oe == 1'b0, "R1", "mem_wd_oe", 32'(mem_wd_oe), 32'd0);
        chk(mem_wd_rise == '0 && mem_wd_fall == '0, "R1", "write lanes", 32'(mem_wd_rise), 32'd0);
        chk(rd_valid == 1'b0, "R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk(rd_word0 == '0 && rd_word1 == '0, "R1", "read words", 32'(rd_word0), 32'd0);
        chk(ready == 1'b1, "R1", "ready", 32'(ready), 32'd1);
        rst_n = 1'b1;

        // R7: idle cycles with changing garbage on the read lanes
        push_idle(4);
        // R4/R8: even and odd start addresses, then read back
        push_wr(6, 16'hA0A0, 16'h5151);
        push_wr(9, 16'hC3C3, 16'h3C3C);
        push_rd(6);
        push_rd(9);
        push_rd(7);
        push_idle(3);
        // R5: back-to-back writes
        push_wr(10, 16'h1111, 16'h2222);
        push_wr(12, 16'h3333, 16'h4444);
        push_wr(15, 16'h5555, 16'h6666);
        // R9: back-to-back reads
        push_rd(10);
        push_rd(12);
        push_rd(14);
        push_rd(11);
        // R9: read followed by write, then read back
        push_rd(3);
        push_wr(3, 16'hDEAD, 16'hBEEF);
        push_rd(2);
        push_idle(2);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int kind = $urandom_range(0, 9);
            if (kind < 3)      push_idle(1);
            else if (kind < 6) push_wr($urandom_range(0, DEPTH - 1), DW'($urandom), DW'($urandom));
            else               push_rd($urandom_range(0, DEPTH - 1));
        end

        while (sq.size() > 0 || rq.size() > 0) step();
        repeat (5) step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule